// File: doc/BRIEF.md
# Auto-Precharge Bank Spacing Checker

This block sits in a DDR2-style command path and sees one command per clock. Each command has a type, a bank address and an auto-precharge bit. When a read or write with auto-precharge is accepted, the block starts timing how long a command to some other bank must wait. That minimum gap depends on two things: whether the earlier access was a read or a write, and whether the next command is a read, a write, or a precharge/activate. It also depends on the configured CAS latency, burst length and write-to-read turnaround.

A command that respects its gap is forwarded one clock later with its type, bank and auto-precharge bit unchanged. A command that comes too early is not forwarded. In its place the block emits a NOP and raises a single-cycle violation flag that carries the offending command type. Inside the block there is one down-counter for each destination class, and all three are loaded together when an auto-precharge read or write is accepted. Timing within the same bank is left to other logic.

Top module: `ap_spacing_checker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the forwarded type is NOP (0) and the violation flag is low. All spacing counters are cleared, so the first command after reset is always forwarded.
- R2: Type codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, and codes 5 to 7 are treated as NOP. An accepted command appears on the forward outputs one clock after it is presented, with its type, bank and auto-precharge bit unchanged.
- R3: A read to a bank other than the one named by the last accepted auto-precharge write waits at least (CL-1)+BL/2+tWTR clocks after that write. CL is cfg_cl_i (3 to 6), tWTR is cfg_twtr_i (1 to 4), and BL is 8 when cfg_bl8_i is 1 and 4 when it is 0.
- R4: After an accepted auto-precharge write, a write to a different bank waits at least BL/2 clocks.
- R5: After an accepted auto-precharge read, a read to a different bank waits at least BL/2 clocks.
- R6: After an accepted auto-precharge read, a write to a different bank waits at least BL/2+2 clocks.
- R7: An activate or precharge needs only a one-clock gap after either kind of auto-precharge access, so it never raises a violation.
- R8: A command that arrives sooner than its gap allows is replaced on the forward outputs by type NOP, bank 0 and auto-precharge 0. In that same cycle the violation flag pulses high for one clock and the violation type carries the command's code. When there is no violation, the violation type reads 0.
- R9: A command addressed to the same bank as the last accepted auto-precharge access is not spacing-checked, and it is forwarded.
- R10: Only an accepted read or write with auto-precharge loads the counters. A rejected command and a read or write without auto-precharge leave them untouched. When a new auto-precharge access arrives while counters are still running, each counter keeps whichever of the old remaining gap and the new gap is longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_cl_i | input | 3 | CAS latency in clocks, 3 to 6 |
| cfg_bl8_i | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cfg_twtr_i | input | 3 | Write-to-read turnaround in clocks, 1 to 4 |
| cmd_type_i | input | 3 | Incoming command type |
| cmd_bank_i | input | BANK_W | Incoming bank address |
| cmd_ap_i | input | 1 | Incoming auto-precharge bit |
| fwd_type_o | output | 3 | Forwarded command type (NOP when blocked) |
| fwd_bank_o | output | BANK_W | Forwarded bank address |
| fwd_ap_o | output | 1 | Forwarded auto-precharge bit |
| viol_o | output | 1 | One-cycle spacing violation pulse |
| viol_type_o | output | 3 | Type of the rejected command |

## Verification
The assertions assume that the configuration inputs stay inside their legal ranges and do not change while any counter is running. Under that assumption the shortest write-to-read gap is always longer than one clock, and no activate or precharge can ever be flagged. The stimulus sets a new configuration only after at least twenty idle NOP cycles, and it uses only legal values. It sweeps every source and destination pairing across gaps from one clock up to one past the required value, and then runs pseudo-random traffic with the bank spread over four values.

// File: rtl/ap_chk_pkg.sv
package ap_chk_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  localparam int NUM_CLS = 3;
  localparam int CLS_RD  = 0;
  localparam int CLS_WR  = 1;
  localparam int CLS_PA  = 2;
endpackage

// File: rtl/ap_gap_calc.sv
module ap_gap_calc
  import ap_chk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [2:0]                      cfg_cl_i,
  input  logic                            cfg_bl8_i,
  input  logic [2:0]                      cfg_twtr_i,
  input  logic                            src_wr_i,
  output logic [NUM_CLS-1:0][CNT_W-1:0]   load_o
);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] HALF_BL4 = CNT_W'(2);
  localparam logic [CNT_W-1:0] HALF_BL8 = CNT_W'(4);
  localparam logic [CNT_W-1:0] RD_WR_EX = CNT_W'(2);

  logic [CNT_W-1:0] half_bl;
  logic [CNT_W-1:0] gap_rd, gap_wr, gap_pa;

  assign half_bl = cfg_bl8_i ? HALF_BL8 : HALF_BL4;

  always_comb begin
    gap_pa = ONE;
    if (src_wr_i) begin
      gap_rd = CNT_W'(cfg_cl_i) - ONE + half_bl + CNT_W'(cfg_twtr_i);
      gap_wr = half_bl;
    end else begin
      gap_rd = half_bl;
      gap_wr = half_bl + RD_WR_EX;
    end
  end

  // counters hold gap-1: a command at issue+gap sees zero
  assign load_o[CLS_RD] = gap_rd - ONE;
  assign load_o[CLS_WR] = gap_wr - ONE;
  assign load_o[CLS_PA] = gap_pa - ONE;
endmodule

// File: rtl/ap_class_counter.sv
module ap_class_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q, cnt_dec, cnt_d;

  assign cnt_dec = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);

  always_comb begin
    cnt_d = cnt_dec;
    if (load_i && (load_val_i > cnt_dec)) cnt_d = load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  a_r10_keep_longer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q >= $past(load_val_i));
  a_r10_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/ap_spacing_checker.sv
module ap_spacing_checker
  import ap_chk_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cfg_cl_i,
  input  logic              cfg_bl8_i,
  input  logic [2:0]        cfg_twtr_i,
  input  logic [2:0]        cmd_type_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  input  logic              cmd_ap_i,
  output logic [2:0]        fwd_type_o,
  output logic [BANK_W-1:0] fwd_bank_o,
  output logic              fwd_ap_o,
  output logic              viol_o,
  output logic [2:0]        viol_type_o
);
  logic [NUM_CLS-1:0][CNT_W-1:0] load_val;
  logic [NUM_CLS-1:0]            busy;
  logic [NUM_CLS-1:0]            cls_hit;
  logic                          is_rd, is_wr, is_pa, live, blocked, accept, ap_load;
  logic [BANK_W-1:0]             ap_bank_q;

  assign is_rd = (cmd_type_i == CMD_RD);
  assign is_wr = (cmd_type_i == CMD_WR);
  assign is_pa = (cmd_type_i == CMD_ACT) || (cmd_type_i == CMD_PRE);
  assign live  = is_rd | is_wr | is_pa;

  assign cls_hit[CLS_RD] = is_rd;
  assign cls_hit[CLS_WR] = is_wr;
  assign cls_hit[CLS_PA] = is_pa;

  assign blocked = |(cls_hit & busy) && (cmd_bank_i != ap_bank_q);
  assign accept  = live && !blocked;
  assign ap_load = accept && cmd_ap_i && (is_rd || is_wr);

  ap_gap_calc #(.CNT_W(CNT_W)) u_gap (
    .cfg_cl_i  (cfg_cl_i),
    .cfg_bl8_i (cfg_bl8_i),
    .cfg_twtr_i(cfg_twtr_i),
    .src_wr_i  (is_wr),
    .load_o    (load_val)
  );

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    ap_class_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (ap_load),
      .load_val_i(load_val[c]),
      .busy_o    (busy[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ap_bank_q   <= '0;
      fwd_type_o  <= CMD_NOP;
      fwd_bank_o  <= '0;
      fwd_ap_o    <= 1'b0;
      viol_o      <= 1'b0;
      viol_type_o <= CMD_NOP;
    end else begin
      if (ap_load) ap_bank_q <= cmd_bank_i;
      fwd_type_o  <= accept ? cmd_type_i : CMD_NOP;
      fwd_bank_o  <= accept ? cmd_bank_i : '0;
      fwd_ap_o    <= accept && cmd_ap_i;
      viol_o      <= live && blocked;
      viol_type_o <= (live && blocked) ? cmd_type_i : CMD_NOP;
    end
  end

  a_r2_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (fwd_type_o == $past(cmd_type_i)) && (fwd_bank_o == $past(cmd_bank_i)));
  a_r3_wr_ap_arms_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_load && is_wr) |=> busy[CLS_RD]);
  a_r7_pa_never_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (viol_type_o == CMD_RD || viol_type_o == CMD_WR));
  a_r8_flag_drops_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (fwd_type_o == CMD_NOP) && !fwd_ap_o);
  a_r9_same_bank_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cmd_bank_i == ap_bank_q) |=> !viol_o);
endmodule

// File: tb/tb_ap_spacing_checker.sv
module tb_ap_spacing_checker;
  localparam int BANK_W = 3;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        cfg_cl = 3'd4;
  logic              cfg_bl8 = 1'b0;
  logic [2:0]        cfg_twtr = 3'd2;
  logic [2:0]        cmd_type = NOP;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic              cmd_ap = 1'b0;
  logic [2:0]        fwd_type, viol_type;
  logic [BANK_W-1:0] fwd_bank;
  logic              fwd_ap, viol;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic [2:0]        t;
    logic [BANK_W-1:0] b;
    logic              ap;
    logic              v;
    logic [2:0]        vt;
    string             req;
  } exp_t;
  exp_t sb[$];

  int mc[3];
  int mbank = 0;

  always #10 clk = ~clk;

  ap_spacing_checker #(.BANK_W(BANK_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_cl_i(cfg_cl), .cfg_bl8_i(cfg_bl8), .cfg_twtr_i(cfg_twtr),
    .cmd_type_i(cmd_type), .cmd_bank_i(cmd_bank), .cmd_ap_i(cmd_ap),
    .fwd_type_o(fwd_type), .fwd_bank_o(fwd_bank), .fwd_ap_o(fwd_ap),
    .viol_o(viol), .viol_type_o(viol_type)
  );

  task automatic send(input logic [2:0] t, input int b, input logic ap, input string req);
    int cls, half, hb;
    int g[3];
    logic blk;
    exp_t e;
    @(negedge clk);
    cmd_type = t; cmd_bank = BANK_W'(b); cmd_ap = ap;
    cls  = (t == RD) ? 0 : (t == WR) ? 1 : (t == ACT || t == PRE) ? 2 : -1;
    blk  = (cls >= 0) && (mc[cls > 0 ? cls : 0] > 0) && (b != mbank);
    e.req = req;
    if (cls < 0 || blk) begin
      e.t = NOP; e.b = '0; e.ap = 1'b0;
    end else begin
      e.t = t; e.b = BANK_W'(b); e.ap = ap;
    end
    e.v  = blk;
    e.vt = blk ? t : NOP;
    sb.push_back(e);
    for (int k = 0; k < 3; k++) if (mc[k] > 0) mc[k]--;
    if (!blk && ap && (t == RD || t == WR)) begin
      half = cfg_bl8 ? 4 : 2;
      hb   = half;
      if (t == WR) begin g[0] = int'(cfg_cl) - 1 + hb + int'(cfg_twtr); g[1] = hb; end
      else         begin g[0] = hb; g[1] = hb + 2; end
      g[2] = 1;
      for (int k = 0; k < 3; k++) if (g[k] - 1 > mc[k]) mc[k] = g[k] - 1;
      mbank = b;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(NOP, 0, 1'b0, "R2");
  endtask

  // monitor: pops one expected item per clock, samples mid-cycle
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (fwd_type !== e.t || fwd_bank !== e.b || fwd_ap !== e.ap ||
          viol !== e.v || viol_type !== e.vt) begin
        n_fail++;
        $display("FAIL %s: got t=%0d b=%0d ap=%0d v=%0d vt=%0d exp t=%0d b=%0d ap=%0d v=%0d vt=%0d",
                 e.req, fwd_type, fwd_bank, fwd_ap, viol, viol_type,
                 e.t, e.b, e.ap, e.v, e.vt);
      end
    end
  end

  task automatic sweep(input logic [2:0] src, input logic [2:0] dst, input string req);
    for (int gap = 1; gap <= 15; gap++) begin
      send(src, 0, 1'b1, req);
      if (gap > 1) idle(gap - 1);
      send(dst, 1, 1'b0, req);
      idle(16);
    end
  endtask

  task automatic set_cfg(input int cl, input logic bl8, input int tw);
    idle(20);
    @(negedge clk);
    cfg_cl = 3'(cl); cfg_bl8 = bl8; cfg_twtr = 3'(tw);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int cfgs_cl[3] = '{4, 3, 6};
    int cfgs_tw[3] = '{2, 1, 4};
    logic cfgs_bl[3] = '{1'b0, 1'b1, 1'b1};
    for (int k = 0; k < 3; k++) mc[k] = 0;
    repeat (3) @(posedge clk);
    #5;
    n_chk++;
    if (fwd_type !== NOP || viol !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got t=%0d v=%0d exp t=0 v=0", fwd_type, viol);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1: first command after reset is forwarded
    send(RD, 1, 1'b0, "R1");
    send(WR, 5, 1'b1, "R2");
    idle(20);
    // R2: illegal codes treated as NOP
    send(3'd6, 2, 1'b1, "R2");
    send(ACT, 3, 1'b0, "R2");
    idle(4);

    for (int c = 0; c < 3; c++) begin
      set_cfg(cfgs_cl[c], cfgs_bl[c], cfgs_tw[c]);
      sweep(WR, RD,  "R3");
      sweep(WR, WR,  "R4");
      sweep(RD, RD,  "R5");
      sweep(RD, WR,  "R6");
      sweep(WR, ACT, "R7");
      sweep(RD, PRE, "R7");
      // R8: early read flagged
      send(WR, 2, 1'b1, "R8"); send(RD, 3, 1'b1, "R8"); idle(16);
      // R9: same bank unchecked
      send(WR, 4, 1'b1, "R9"); send(RD, 4, 1'b0, "R9"); send(WR, 4, 1'b0, "R9"); idle(16);
      // R10: rejected AP read must not load, plain write must not load
      send(WR, 0, 1'b1, "R10"); send(RD, 1, 1'b1, "R10");
      send(WR, 2, 1'b0, "R10"); send(WR, 2, 1'b0, "R10"); idle(16);
      send(WR, 5, 1'b0, "R10"); send(RD, 6, 1'b0, "R10"); idle(4);
      // R10: overlapping AP accesses keep longer gap
      send(WR, 0, 1'b1, "R10"); idle(1); send(WR, 0, 1'b1, "R10");
      send(RD, 7, 1'b1, "R10"); idle(2); send(RD, 7, 1'b0, "R10"); idle(16);
    end

    set_cfg(5, 1'b0, 3);
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      int r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = int'(lfsr[2:0]) % 5;
      send(3'(r), int'(lfsr[5:4]), lfsr[8], "R10");
    end
    idle(4);
    @(posedge clk); #6;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule